// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the early dwords of a type-0 configuration header for a 33 MHz multimedia endpoint. Configuration accesses select a dword by index, and writes are qualified per byte lane. Three dwords are implemented:

- index 1: the command and status halves;
- index 2: the revision and class code;
- index 3: the cache line size and latency timer.

Reads of any other index return zero, and writes to any other index do nothing.

The bus engine reports errors through five single-cycle event pulses, synchronous to `clk`. Each pulse sets a sticky status flag, and software clears a flag by writing one to its bit. A lock input from the setup logic makes the class code read-only. A second input supplies the 66 MHz capability bit. The command half is also driven out so that the bus engine can see its enables.

Top module: `pci_cfg_header_regs`

## Requirements
- R1: After reset, the following all read zero: the command half, the five status flags, the latency timer and the cache line size. The class code reads CLASS_RST (0x048000) and the revision reads REV_ID.
- R2: Index 1 returns the command in bits 15:0 and the status in bits 31:16. In the status half, bits 26:25 read 01, bit 23 reads 1 and bit 20 reads 1. Bits 31, 22 and 19:16 read 0. Bit 21 follows `cap_66mhz`.
- R3: Command bits 9, 8, 6, 4, 2 and 1 are writable. Command bits 15:10, 7, 5, 3 and 0 always read 0. `cmd_out` equals the command half.
- R4: Each event pulse sets one status flag on the next clock edge: `ev_serr` sets bit 30, `ev_rx_mabort` sets bit 29, `ev_rx_tabort` sets bit 28, `ev_sig_tabort` sets bit 27 and `ev_perr` sets bit 24. A flag stays set until it is cleared.
- R5: A write to index 1 with byte lane 3 enabled clears each of the five flags whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R6: When a flag's event pulse and a clearing write arrive in the same cycle, the flag ends up set.
- R7: While `setup_locked` is 0, a write to index 2 loads class code bytes from lanes 1 to 3. The revision in bits 7:0 is never written.
- R8: While `setup_locked` is 1, writes to index 2 leave the class code unchanged.
- R9: At index 3, bits 15:8 (latency timer) and bits 7:0 (cache line size) are writable. Bits 31:16 read 0.
- R10: Byte lane k covers data bits 8k+7:8k. A lane whose enable bit is 0 leaves its register bits unchanged.
- R11: Reads of index 0 and of indices above 3 return 0. Writes to those indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the addressed dword |
| cfg_dw_idx | input | ADDR_W | Dword index (byte offset divided by 4) |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_dw_idx`, combinational |
| ev_serr | input | 1 | System error signalled |
| ev_rx_mabort | input | 1 | Master received a master abort |
| ev_rx_tabort | input | 1 | Master received a target abort |
| ev_sig_tabort | input | 1 | Target signalled a target abort |
| ev_perr | input | 1 | Master observed a parity error |
| setup_locked | input | 1 | Setup register written; freezes the class code |
| cap_66mhz | input | 1 | Value reported in status bit 21 |
| cmd_out | output | 16 | Current command half |

## Verification
Every register is visible on `cfg_rdata` in the cycle after the edge that updated it, and the command half is also visible on `cmd_out`. A lane-enable mistake or a wrong writable mask therefore shows up on the very next read. The sweep writes every byte-enable combination with several data patterns to every index. After each write it reads back all indices, so a stray write to a neighbouring dword is exposed within one access. All five flags are set before every write, so a clear that fires from the wrong lane or bit is caught on the next read. A lost event shows up the same way, and so does an error in the set-over-clear priority.

// File: rtl/pci_cfg_header_regs.sv
module pci_cfg_header_regs #(
  parameter int          ADDR_W    = 6,
  parameter logic [23:0] CLASS_RST = 24'h048000,
  parameter logic [7:0]  REV_ID    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_dw_idx,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ev_serr,
  input  logic              ev_rx_mabort,
  input  logic              ev_rx_tabort,
  input  logic              ev_sig_tabort,
  input  logic              ev_perr,
  input  logic              setup_locked,
  input  logic              cap_66mhz,
  output logic [15:0]       cmd_out
);

  localparam logic [15:0]       CMD_RW  = 16'h0356;
  localparam logic [ADDR_W-1:0] IDX_CMD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX_CC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IDX_LAT = ADDR_W'(3);

  logic [15:0] cmd_q;
  logic [4:0]  flags_q;
  logic [23:0] class_q;
  logic [15:0] lat_q;

  wire wr_cmd = cfg_wr && (cfg_dw_idx == IDX_CMD);
  wire wr_cc  = cfg_wr && (cfg_dw_idx == IDX_CC);
  wire wr_lat = cfg_wr && (cfg_dw_idx == IDX_LAT);

  wire [4:0] ev_vec = {ev_serr, ev_rx_mabort, ev_rx_tabort, ev_sig_tabort, ev_perr};
  wire [4:0] clr_vec = (wr_cmd && cfg_be[3]) ?
      {cfg_wdata[30], cfg_wdata[29], cfg_wdata[28], cfg_wdata[27], cfg_wdata[24]} : 5'b0;

  wire [15:0] status = {1'b0, flags_q[4:1], 2'b01, flags_q[0],
                        1'b1, 1'b0, cap_66mhz, 1'b1, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      flags_q <= '0;
      class_q <= CLASS_RST;
      lat_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | ev_vec;
      for (int b = 0; b < 2; b++) begin
        if (wr_cmd && cfg_be[b]) cmd_q[b*8 +: 8] <= cfg_wdata[b*8 +: 8] & CMD_RW[b*8 +: 8];
        if (wr_lat && cfg_be[b]) lat_q[b*8 +: 8] <= cfg_wdata[b*8 +: 8];
      end
      for (int b = 1; b < 4; b++) begin
        if (wr_cc && !setup_locked && cfg_be[b])
          class_q[(b-1)*8 +: 8] <= cfg_wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    case (cfg_dw_idx)
      IDX_CMD: cfg_rdata = {status, cmd_q};
      IDX_CC:  cfg_rdata = {class_q, REV_ID};
      IDX_LAT: cfg_rdata = {16'h0000, lat_q};
      default: cfg_rdata = 32'h0;
    endcase
  end

  assign cmd_out = cmd_q;

  assert_event_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serr |=> flags_q[4]);

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_perr && wr_cmd && cfg_be[3] && cfg_wdata[24]) |=> cfg_rdata[24] || cfg_dw_idx != IDX_CMD);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cfg_be[3] && cfg_wdata[30] && !ev_serr) |=> !flags_q[4]);

  assert_class_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    setup_locked |=> class_q == $past(class_q));

  assert_unimpl_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_dw_idx != IDX_CMD && cfg_dw_idx != IDX_CC && cfg_dw_idx != IDX_LAT)
      |=> $stable(cmd_q) && $stable(class_q) && $stable(lat_q));

  assert_cmd_ro_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out & ~CMD_RW) == 16'h0);

endmodule

// File: tb/test_pci_cfg_header_regs.sv
module test_pci_cfg_header_regs;
  localparam int ADDR_W = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [ADDR_W-1:0] cfg_dw_idx = '0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic ev_serr = 0, ev_rx_mabort = 0, ev_rx_tabort = 0, ev_sig_tabort = 0, ev_perr = 0;
  logic setup_locked = 0, cap_66mhz = 0;
  logic [15:0] cmd_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_cmd;
  logic [4:0]  m_fl;
  logic [23:0] m_cls;
  logic [15:0] m_lat;

  always #2 clk = ~clk;

  pci_cfg_header_regs #(.ADDR_W(ADDR_W)) i_pci_cfg_header_regs (
    .clk, .rst_n, .cfg_wr, .cfg_dw_idx, .cfg_be, .cfg_wdata, .cfg_rdata,
    .ev_serr, .ev_rx_mabort, .ev_rx_tabort, .ev_sig_tabort, .ev_perr,
    .setup_locked, .cap_66mhz, .cmd_out);

  function automatic logic [31:0] expect_rd(int idx);
    logic [15:0] st;
    st = 16'h0;
    st[14] = m_fl[4]; st[13] = m_fl[3]; st[12] = m_fl[2]; st[11] = m_fl[1];
    st[8] = m_fl[0];
    st[10:9] = 2'b01; st[7] = 1'b1; st[5] = cap_66mhz; st[4] = 1'b1;
    case (idx)
      1: return {st, m_cmd};
      2: return {m_cls, 8'h00};
      3: return {16'h0, m_lat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_dw_idx = ADDR_W'(i);
      #1;
      check(req, cfg_rdata, expect_rd(i));
    end
    check({req, " R3 cmd_out"}, {16'h0, cmd_out}, {16'h0, m_cmd});
  endtask

  task automatic pulse_events(logic [4:0] ev, logic do_wr, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    {ev_serr, ev_rx_mabort, ev_rx_tabort, ev_sig_tabort, ev_perr} = ev;
    cfg_wr = do_wr; cfg_dw_idx = ADDR_W'(1); cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    {ev_serr, ev_rx_mabort, ev_rx_tabort, ev_sig_tabort, ev_perr} = 5'b0;
    cfg_wr = 0;
    if (do_wr && be[3])
      m_fl = m_fl & ~{d[30], d[29], d[28], d[27], d[24]};
    m_fl = m_fl | ev;
  endtask

  task automatic write(int idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_dw_idx = ADDR_W'(idx); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        if (idx == 1 && b < 2) m_cmd[b*8 +: 8] = d[b*8 +: 8] & (b == 0 ? 8'h56 : 8'h03);
        if (idx == 3 && b < 2) m_lat[b*8 +: 8] = d[b*8 +: 8];
        if (idx == 2 && b > 0 && !setup_locked) m_cls[(b-1)*8 +: 8] = d[b*8 +: 8];
      end
    end
    if (idx == 1 && be[3]) m_fl = m_fl & ~{d[30], d[29], d[28], d[27], d[24]};
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
    m_cmd = '0; m_fl = '0; m_cls = 24'h048000; m_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    read_all("R1 reset");

    cap_66mhz = 1;
    read_all("R2 cap bit set");
    cap_66mhz = 0;

    for (int e = 0; e < 5; e++) begin
      pulse_events(5'b1 << e, 0, 32'h0, 4'h0);
      read_all("R4 event set");
    end
    write(1, 4'h7, 32'hFFFF_FFFF);
    read_all("R5 no clear without lane 3");
    write(1, 4'h8, 32'h4000_0000);
    read_all("R5 clear bit30 only");

    pulse_events(5'b11111, 1, 32'hFFFF_FFFF, 4'hF);
    read_all("R6 set wins");

    for (int lk = 0; lk < 2; lk++) begin
      setup_locked = lk[0];
      cap_66mhz = lk[0];
      for (int p = 0; p < 4; p++) begin
        for (int be = 0; be < 16; be++) begin
          for (int idx = 0; idx < 8; idx++) begin
            pulse_events(5'b11111, 0, 32'h0, 4'h0);
            write(idx, be[3:0], pats[p] ^ (32'h0101_0101 * idx));
            if (idx == 2) read_all(lk ? "R8 R10 class" : "R7 R10 class");
            else if (idx == 1) read_all("R3 R5 R10 cmd/status");
            else if (idx == 3) read_all("R9 R10 lat/cls");
            else read_all("R11 unimplemented");
          end
        end
      end
    end
    done = 1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end
endmodule